// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block watches a small set of memory-controller activity pulses and counts them for software. It holds one free-running cycle counter and four 32-bit event counters. Each event counter is pointed at one event kind through a select field: all reads, reads that target one chosen bank, all writes, writes that target one chosen bank, column commands issued, page hits, or cycles in which the data bus is busy. Software reaches everything through an APB slave port.

Counting is gated three ways. A separate clock-enable register must be on, a global enable in the control register must be on, and each counter has its own enable. Counter enables and interrupt enables each sit behind a pair of registers: one that only sets bits and one that only clears them, so one agent can change a single bit without a read-modify-write. A counter that rolls over from all ones raises a sticky overflow flag, and any flag whose interrupt enable is set drives the interrupt line.

While the clock enable is off, the counter registers read as zero, writes to them are dropped, and no counter changes. The event pulses are made elsewhere, and the whole block runs on one clock.

Top module: `perf_event_monitor`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `pready` is high; `pready` stays high at all times.
- R2: The clock-enable register at offset 0x0130, bit 0, gates counter access: while it is 0, reads of 0xE100, 0xE110, 0xE120, 0xE130 and 0xE140 return zero, writes to them are ignored, and no counter changes.
- R3: In every enable-type register (0xE010/0xE020 counter enables, 0xE030/0xE040 interrupt enables, 0xE050 flags), bit 31 stands for the cycle counter and bits 0..3 for event counters 0..3. A 1 written to a set register (0xE010, 0xE030) sets that enable. A 1 written to a clear register (0xE020, 0xE040) clears it. A 0 changes nothing, and both registers of a pair read back the current enables.
- R4: The cycle counter at 0xE100 grows by one on every clock edge at which the clock enable, the global enable (control bit 0 at 0xE000) and its enable bit are all set.
- R5: Event counter k (at 0xE110 + 0x10·k) grows by one on each clock edge at which its selected event pulses and the clock enable, the global enable and its enable bit k are all set. With any of these clear it holds.
- R6: The select register at 0xE060 holds a 4-bit code per event counter in bits [4k+3:4k] and a bank number in bits [18:16]. Code 1 counts all reads, 2 reads whose bank equals the bank number, 3 all writes, 4 writes to that bank, 5 column commands, 6 page hits and 7 busy data-bus cycles. Code 0 and codes 8..15 count nothing.
- R7: With the clock enable on, a counter register written over APB takes the written value, and that write wins over an increment in the same cycle.
- R8: A counter that increments from 0xFFFFFFFF wraps to zero and sets its bit in the flag register 0xE050. Writing 1 to a flag bit clears it, and a wrap in the same cycle wins.
- R9: `irq` is high exactly when some flag bit and the same interrupt-enable bit are both set.
- R10: Control bit 1 zeroes all event counters and bit 2 zeroes the cycle counter. Both act only while the clock enable is on and read back as 0. Control bit 0 reads back as written.
- R11: Reads of any offset not listed above return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | 16 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| ev_rd | input | 1 | One-cycle pulse per read request |
| ev_rd_bank | input | 3 | Bank of the read request in that cycle |
| ev_wr | input | 1 | One-cycle pulse per write request |
| ev_wr_bank | input | 3 | Bank of the write request in that cycle |
| ev_col | input | 1 | Pulse per column command scheduled |
| ev_hit | input | 1 | Pulse per page hit |
| ev_busy | input | 1 | High for each data-bus busy cycle |
| irq | output | 1 | Overflow interrupt |

## Verification
A table of pulse bursts is run with all seven event codes, plus an unused and a zero code. Each burst mixes several event kinds in different amounts, so a counter that follows the wrong input ends with the wrong total. Bank-filtered codes are tried with a matching and a mismatched bank number, which separates a real bank compare from a plain read or write count. Directed cases then drive the clock-enable, global-enable and per-counter enable gates one at a time. They also check an exact cycle count across a known enable window, a rollover from 0xFFFFFFFE with the interrupt masked and then unmasked, and the two self-clearing counter resets, which must each act on their own group only.

// File: rtl/pmon_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the performance monitor.
// Holds the register offsets and the event-select code values.
package pmon_pkg;

    localparam int DATA_W = 32;

    // Register offsets (byte addresses on the APB port)
    localparam int ADDR_GATE   = 'h0130;
    localparam int ADDR_CTRL   = 'hE000;
    localparam int ADDR_ENSET  = 'hE010;
    localparam int ADDR_ENCLR  = 'hE020;
    localparam int ADDR_INTSET = 'hE030;
    localparam int ADDR_INTCLR = 'hE040;
    localparam int ADDR_FLAG   = 'hE050;
    localparam int ADDR_EVCFG  = 'hE060;
    localparam int ADDR_CYC    = 'hE100;
    localparam int ADDR_EVT0   = 'hE110;
    localparam int CNT_STRIDE  = 'h10;

    // Bit position of the bank number inside the select register
    localparam int BANK_LSB = 16;

    // Event-select codes
    typedef enum logic [3:0] {
        EV_NONE    = 4'd0,
        EV_RD_ALL  = 4'd1,
        EV_RD_BANK = 4'd2,
        EV_WR_ALL  = 4'd3,
        EV_WR_BANK = 4'd4,
        EV_COL     = 4'd5,
        EV_HIT     = 4'd6,
        EV_BUSY    = 4'd7
    } ev_code_e;

endpackage

// File: rtl/pmon_evsel.sv
`timescale 1ns/1ps
// Module: pmon_evsel
// Turns the raw event pulses into one count pulse for one counter,
// based on that counter's 4-bit select code and the shared bank number.
// Assumes event inputs are single-cycle pulses in the monitor clock.
module pmon_evsel
    import pmon_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic [3:0]        code,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              ev_rd,
    input  logic [BANK_W-1:0] ev_rd_bank,
    input  logic              ev_wr,
    input  logic [BANK_W-1:0] ev_wr_bank,
    input  logic              ev_col,
    input  logic              ev_hit,
    input  logic              ev_busy,
    output logic              pulse
);

    logic rd_match;
    logic wr_match;

    assign rd_match = ev_rd & (ev_rd_bank == bank_sel);
    assign wr_match = ev_wr & (ev_wr_bank == bank_sel);

    // Pick the event named by the code; unknown codes count nothing
    always_comb begin
        case (code)
            EV_RD_ALL:  pulse = ev_rd;
            EV_RD_BANK: pulse = rd_match;
            EV_WR_ALL:  pulse = ev_wr;
            EV_WR_BANK: pulse = wr_match;
            EV_COL:     pulse = ev_col;
            EV_HIT:     pulse = ev_hit;
            EV_BUSY:    pulse = ev_busy;
            default:    pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmon_counter.sv
`timescale 1ns/1ps
// Module: pmon_counter
// One wrapping counter with a synchronous clear and a load port.
// Priority is clear, then load, then increment. A wrap is flagged for one
// cycle when an increment takes the value from all ones to zero.
module pmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    assign wrap = inc & ~ld & ~clr & (&cnt);

    // Update the count by clear, load or increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/pmon_regs.sv
`timescale 1ns/1ps
// Module: pmon_regs
// APB register file of the monitor: clock enable, control, set/clear
// enable pairs, overflow flags, event select, and the counter read mux.
// Index N_EV of every per-counter vector is the cycle counter and maps to
// register bit 31; indices 0..N_EV-1 map to bits 0..N_EV-1.
// Assumes N_EV <= 4 so the select codes fit below the bank field.
module pmon_regs
    import pmon_pkg::*;
#(
    parameter int N_EV   = 4,
    parameter int BANK_W = 3,
    parameter int AW     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [AW-1:0]                 paddr,
    input  logic [DATA_W-1:0]             pwdata,
    output logic [DATA_W-1:0]             prdata,
    input  logic [N_EV:0][DATA_W-1:0]     cnt_val,
    input  logic [N_EV:0]                 wrap,
    output logic                          gate_q,
    output logic                          glob_q,
    output logic [N_EV:0]                 cnt_en_q,
    output logic [N_EV:0]                 int_en_q,
    output logic [N_EV:0]                 flag_q,
    output logic [N_EV:0]                 ld_stb,
    output logic [N_EV:0]                 clr_stb,
    output logic [N_EV-1:0][3:0]          evsel_q,
    output logic [BANK_W-1:0]             bank_sel_q
);

    localparam int N_TOT = N_EV + 1;
    localparam int CYC   = N_EV;

    logic             wr_acc;
    logic             ctrl_wr;
    logic [N_TOT-1:0] wbits;
    logic [N_TOT-1:0] cnt_hit;
    logic [N_TOT-1:0] en_set_m, en_clr_m, int_set_m, int_clr_m, flag_clr_m;
    logic             unused_wdata;

    assign wr_acc = psel & penable & pwrite;

    // Map a per-counter vector onto register bit positions
    function automatic logic [DATA_W-1:0] to_word(input logic [N_TOT-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int k = 0; k < N_EV; k++) w[k] = v[k];
        w[DATA_W-1] = v[CYC];
        return w;
    endfunction

    // Gather the written mask bits in counter-index order
    always_comb begin
        wbits = '0;
        for (int k = 0; k < N_EV; k++) wbits[k] = pwdata[k];
        wbits[CYC] = pwdata[DATA_W-1];
    end

    assign unused_wdata = ^pwdata[DATA_W-2:BANK_LSB+BANK_W];

    // Decode which counter register the address names
    always_comb begin
        for (int k = 0; k < N_EV; k++)
            cnt_hit[k] = (paddr == AW'(ADDR_EVT0 + CNT_STRIDE * k));
        cnt_hit[CYC] = (paddr == AW'(ADDR_CYC));
    end

    // Build the set and clear masks for each write target
    always_comb begin
        en_set_m   = (wr_acc && paddr == AW'(ADDR_ENSET))  ? wbits : '0;
        en_clr_m   = (wr_acc && paddr == AW'(ADDR_ENCLR))  ? wbits : '0;
        int_set_m  = (wr_acc && paddr == AW'(ADDR_INTSET)) ? wbits : '0;
        int_clr_m  = (wr_acc && paddr == AW'(ADDR_INTCLR)) ? wbits : '0;
        flag_clr_m = (wr_acc && paddr == AW'(ADDR_FLAG))   ? wbits : '0;
    end

    assign ctrl_wr = wr_acc & gate_q & (paddr == AW'(ADDR_CTRL));
    assign ld_stb  = {N_TOT{wr_acc & gate_q}} & cnt_hit;

    // Self-clearing counter resets from control bits 1 and 2
    always_comb begin
        for (int k = 0; k < N_EV; k++) clr_stb[k] = ctrl_wr & pwdata[1];
        clr_stb[CYC] = ctrl_wr & pwdata[2];
    end

    // Clock-enable and global-enable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            glob_q <= 1'b0;
        end else begin
            if (wr_acc && paddr == AW'(ADDR_GATE)) gate_q <= pwdata[0];
            if (wr_acc && paddr == AW'(ADDR_CTRL)) glob_q <= pwdata[0];
        end
    end

    // Counter and interrupt enables through their set/clear pairs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en_q <= '0;
            int_en_q <= '0;
        end else begin
            cnt_en_q <= (cnt_en_q | en_set_m) & ~en_clr_m;
            int_en_q <= (int_en_q | int_set_m) & ~int_clr_m;
        end
    end

    // Sticky overflow flags; a wrap wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~flag_clr_m) | wrap;
        end
    end

    // Event-select codes and bank number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evsel_q    <= '0;
            bank_sel_q <= '0;
        end else if (wr_acc && paddr == AW'(ADDR_EVCFG)) begin
            for (int k = 0; k < N_EV; k++) evsel_q[k] <= pwdata[4*k +: 4];
            bank_sel_q <= pwdata[BANK_LSB +: BANK_W];
        end
    end

    // Read-data mux; counters read zero while the clock enable is off
    always_comb begin
        prdata = '0;
        if (paddr == AW'(ADDR_GATE)) begin
            prdata[0] = gate_q;
        end else if (paddr == AW'(ADDR_CTRL)) begin
            prdata[0] = glob_q;
        end else if (paddr == AW'(ADDR_ENSET) || paddr == AW'(ADDR_ENCLR)) begin
            prdata = to_word(cnt_en_q);
        end else if (paddr == AW'(ADDR_INTSET) || paddr == AW'(ADDR_INTCLR)) begin
            prdata = to_word(int_en_q);
        end else if (paddr == AW'(ADDR_FLAG)) begin
            prdata = to_word(flag_q);
        end else if (paddr == AW'(ADDR_EVCFG)) begin
            for (int k = 0; k < N_EV; k++) prdata[4*k +: 4] = evsel_q[k];
            prdata[BANK_LSB +: BANK_W] = bank_sel_q;
        end else begin
            for (int k = 0; k < N_TOT; k++)
                if (cnt_hit[k] && gate_q) prdata = cnt_val[k];
        end
    end

endmodule

// File: rtl/perf_event_monitor.sv
`timescale 1ns/1ps
// Module: perf_event_monitor (top)
// Cycle counter plus N_EV selectable event counters behind an APB slave,
// with overflow flags feeding one interrupt line.
// Assumes a single clock domain and single-cycle event pulses; the APB
// port never inserts wait states.
module perf_event_monitor
    import pmon_pkg::*;
#(
    parameter int N_EV   = 4,
    parameter int BANK_W = 3,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic              ev_rd,
    input  logic [BANK_W-1:0] ev_rd_bank,
    input  logic              ev_wr,
    input  logic [BANK_W-1:0] ev_wr_bank,
    input  logic              ev_col,
    input  logic              ev_hit,
    input  logic              ev_busy,
    output logic              irq
);

    localparam int N_TOT = N_EV + 1;
    localparam int CYC   = N_EV;

    logic                     gate_q, glob_q;
    logic [N_TOT-1:0]         cnt_en_q, int_en_q, flag_q;
    logic [N_TOT-1:0]         ld_stb, clr_stb, wrap, inc;
    logic [N_TOT-1:0][31:0]   cnt_val;
    logic [N_EV-1:0][3:0]     evsel_q;
    logic [BANK_W-1:0]        bank_sel_q;
    logic [N_EV-1:0]          ev_pulse;

    assign pready = 1'b1;

    pmon_regs #(
        .N_EV   (N_EV),
        .BANK_W (BANK_W),
        .AW     (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .prdata     (prdata),
        .cnt_val    (cnt_val),
        .wrap       (wrap),
        .gate_q     (gate_q),
        .glob_q     (glob_q),
        .cnt_en_q   (cnt_en_q),
        .int_en_q   (int_en_q),
        .flag_q     (flag_q),
        .ld_stb     (ld_stb),
        .clr_stb    (clr_stb),
        .evsel_q    (evsel_q),
        .bank_sel_q (bank_sel_q)
    );

    // One event selector and one counter per event slot
    for (genvar k = 0; k < N_EV; k++) begin : g_evt
        pmon_evsel #(.BANK_W(BANK_W)) u_sel (
            .code       (evsel_q[k]),
            .bank_sel   (bank_sel_q),
            .ev_rd      (ev_rd),
            .ev_rd_bank (ev_rd_bank),
            .ev_wr      (ev_wr),
            .ev_wr_bank (ev_wr_bank),
            .ev_col     (ev_col),
            .ev_hit     (ev_hit),
            .ev_busy    (ev_busy),
            .pulse      (ev_pulse[k])
        );
        assign inc[k] = gate_q & glob_q & cnt_en_q[k] & ev_pulse[k];
    end

    assign inc[CYC] = gate_q & glob_q & cnt_en_q[CYC];

    for (genvar k = 0; k < N_TOT; k++) begin : g_cnt
        pmon_counter #(.W(32)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_stb[k]),
            .ld     (ld_stb[k]),
            .ld_val (pwdata),
            .inc    (inc[k]),
            .cnt    (cnt_val[k]),
            .wrap   (wrap[k])
        );
    end

    assign irq = |(flag_q & int_en_q);

endmodule

// File: rtl/pmon_checker.sv
`timescale 1ns/1ps
// Module: pmon_checker
// Property checks for perf_event_monitor, attached with bind below.
module pmon_checker #(
    parameter int N_EV = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pready,
    input logic                  irq,
    input logic                  gate_q,
    input logic                  glob_q,
    input logic [N_EV:0]         cnt_en_q,
    input logic [N_EV:0]         int_en_q,
    input logic [N_EV:0]         flag_q,
    input logic [N_EV:0]         ld_stb,
    input logic [N_EV:0]         clr_stb,
    input logic [N_EV:0][31:0]   cnt_val
);

    // R1: the port never stalls
    a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        pready);

    // R2: no counter moves while the clock enable is off
    a_r2_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |=> $stable(cnt_val));

    // R4: the cycle counter steps by one when fully enabled and untouched
    a_r4_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && glob_q && cnt_en_q[N_EV] && !ld_stb[N_EV] && !clr_stb[N_EV])
        |=> cnt_val[N_EV] == $past(cnt_val[N_EV]) + 32'd1);

    // R8: an event-counter-0 flag only rises after that counter held all ones
    a_r8_flag_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[0]) |-> $past(cnt_val[0]) == 32'hFFFF_FFFF);

    // R9: without any enabled flag the interrupt stays low
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & int_en_q) == '0) |-> !irq);

endmodule

bind perf_event_monitor pmon_checker #(.N_EV(N_EV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pready   (pready),
    .irq      (irq),
    .gate_q   (gate_q),
    .glob_q   (glob_q),
    .cnt_en_q (cnt_en_q),
    .int_en_q (int_en_q),
    .flag_q   (flag_q),
    .ld_stb   (ld_stb),
    .clr_stb  (clr_stb),
    .cnt_val  (cnt_val)
);

// File: tb/perf_event_monitor_tb.sv
`timescale 1ns/1ps
// Bench: table-driven event counting followed by directed corner cases.
module perf_event_monitor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [15:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        ev_rd = 1'b0, ev_wr = 1'b0, ev_col = 1'b0, ev_hit = 1'b0, ev_busy = 1'b0;
    logic [2:0]  ev_rd_bank = '0, ev_wr_bank = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    perf_event_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .ev_rd(ev_rd), .ev_rd_bank(ev_rd_bank),
        .ev_wr(ev_wr), .ev_wr_bank(ev_wr_bank), .ev_col(ev_col),
        .ev_hit(ev_hit), .ev_busy(ev_busy), .irq(irq)
    );

    // Fields: code, bank, rd_n, rd_bank, wr_n, wr_bank, col_n, hit_n, busy_n, expected
    localparam logic [39:0] VEC [11] = '{
        40'h1032201003, 40'h2232000003, 40'h2532000000, 40'h3010430004,
        40'h4121210002, 40'h5000005205, 40'h6000003606, 40'h7000000177,
        40'h0020202220, 40'h9020202220, 40'h4100320000
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse_rd(input int n, input logic [2:0] b);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ev_rd = 1'b1; ev_rd_bank = b;
            @(negedge clk); ev_rd = 1'b0;
        end
    endtask

    task automatic pulse_wr(input int n, input logic [2:0] b);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ev_wr = 1'b1; ev_wr_bank = b;
            @(negedge clk); ev_wr = 1'b0;
        end
    endtask

    task automatic pulse_misc(input int n_col, input int n_hit, input int n_busy);
        for (int i = 0; i < n_col; i++) begin
            @(negedge clk); ev_col = 1'b1; @(negedge clk); ev_col = 1'b0;
        end
        for (int i = 0; i < n_hit; i++) begin
            @(negedge clk); ev_hit = 1'b1; @(negedge clk); ev_hit = 1'b0;
        end
        for (int i = 0; i < n_busy; i++) begin
            @(negedge clk); ev_busy = 1'b1; @(negedge clk); ev_busy = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pready", {31'b0, pready}, 32'h1);
        apb_rd(16'h0130, rd); check("R1 gate", rd, 32'h0);
        apb_rd(16'hE000, rd); check("R1 ctrl", rd, 32'h0);
        apb_rd(16'hE010, rd); check("R1 enables", rd, 32'h0);
        apb_rd(16'hE050, rd); check("R1 flags", rd, 32'h0);

        // R2: counter write ignored and read masked while clock enable is off
        apb_wr(16'hE110, 32'h0000_1234);
        apb_rd(16'hE110, rd); check("R2 read while gated", rd, 32'h0);
        apb_wr(16'h0130, 32'h1);
        apb_rd(16'h0130, rd); check("R2 gate readback", rd, 32'h1);
        apb_rd(16'hE110, rd); check("R2 write ignored", rd, 32'h0);

        // R3: set/clear enable pairs
        apb_wr(16'hE010, 32'h8000_0005);
        apb_rd(16'hE010, rd); check("R3 set", rd, 32'h8000_0005);
        apb_rd(16'hE020, rd); check("R3 read via clear reg", rd, 32'h8000_0005);
        apb_wr(16'hE020, 32'h0000_0001);
        apb_rd(16'hE010, rd); check("R3 clear one bit", rd, 32'h8000_0004);
        apb_wr(16'hE010, 32'h0);
        apb_rd(16'hE020, rd); check("R3 zero write no effect", rd, 32'h8000_0004);
        apb_wr(16'hE010, 32'h8000_000F);

        // R5/R6: table of event selections
        for (int v = 0; v < 11; v++) begin
            automatic int idx = v % 4;
            automatic logic [39:0] e = VEC[v];
            apb_wr(16'hE000, 32'h3);
            apb_wr(16'hE060, (32'(e[39:36]) << (4 * idx)) | (32'(e[34:32]) << 16));
            pulse_rd(int'(e[31:28]), e[26:24]);
            pulse_wr(int'(e[23:20]), e[18:16]);
            pulse_misc(int'(e[15:12]), int'(e[11:8]), int'(e[7:4]));
            apb_rd(16'(16'hE110 + 16'(idx * 16)), rd);
            check($sformatf("R5 R6 vector %0d", v), rd, 32'(e[3:0]));
        end

        // R4/R10: exact cycle count over a known enable window
        apb_wr(16'hE000, 32'h0);
        apb_wr(16'hE000, 32'h4);
        apb_rd(16'hE100, rd); check("R10 cycle reset", rd, 32'h0);
        apb_wr(16'hE000, 32'h1);
        apb_wr(16'hE000, 32'h0);
        apb_rd(16'hE100, rd); check("R4 cycle count", rd, 32'd3);

        // R5: counter with its enable cleared holds
        apb_wr(16'hE000, 32'h3);
        apb_wr(16'hE020, 32'h2);
        apb_wr(16'hE060, 32'h10);
        pulse_rd(2, 3'd0);
        apb_rd(16'hE120, rd); check("R5 enable bit off", rd, 32'h0);
        apb_wr(16'hE010, 32'h2);

        // R5: global enable off holds every event counter
        apb_wr(16'hE000, 32'h2);
        apb_wr(16'hE060, 32'h1);
        pulse_rd(2, 3'd0);
        apb_rd(16'hE110, rd); check("R5 global off", rd, 32'h0);

        // R7/R8/R9: rollover, flag and interrupt
        apb_wr(16'hE000, 32'h1);
        apb_wr(16'hE110, 32'hFFFF_FFFE);
        apb_rd(16'hE110, rd); check("R7 counter load", rd, 32'hFFFF_FFFE);
        pulse_rd(2, 3'd0);
        apb_rd(16'hE110, rd); check("R8 wrap to zero", rd, 32'h0);
        apb_rd(16'hE050, rd); check("R8 flag set", rd, 32'h1);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        apb_wr(16'hE030, 32'h1);
        @(negedge clk); check("R9 irq raised", {31'b0, irq}, 32'h1);
        apb_wr(16'hE050, 32'h0);
        @(negedge clk); check("R8 zero write keeps flag", {31'b0, irq}, 32'h1);
        apb_wr(16'hE050, 32'h1);
        @(negedge clk); check("R9 irq cleared", {31'b0, irq}, 32'h0);
        apb_rd(16'hE050, rd); check("R8 flag cleared", rd, 32'h0);

        // R10: event reset leaves the cycle counter alone
        apb_wr(16'hE130, 32'd55);
        apb_wr(16'hE000, 32'h3);
        apb_rd(16'hE130, rd); check("R10 event reset", rd, 32'h0);
        apb_rd(16'hE000, rd); check("R10 ctrl readback", rd, 32'h1);
        apb_rd(16'hE100, rd); check("R10 cycle untouched", {31'b0, rd != 0}, 32'h1);
        apb_wr(16'hE000, 32'h4);
        apb_rd(16'hE100, rd); check("R10 cycle reset only", rd, 32'h0);

        // R11: unmapped offset
        apb_rd(16'hE070, rd); check("R11 unmapped", rd, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule